// File: doc/BRIEF.md
# Frequency-Switch Watchdog with Two-Level Fallback

This block guards a programmable clock generator against a frequency change that leaves the system unable to run. Software writes a new frequency code, programs a timeout in half-second steps, and arms the watchdog. A healthy system disarms it in time. If the interval runs out first, the block drives an active-low reset pulse and replaces the active frequency code with a programmed fallback code. It then re-arms itself with the same interval. A second expiry at the fallback frequency causes another reset and hands control of the frequency code back to the external jumper inputs.

Time is measured on a single-cycle `halfTick` strobe. One tick period is half a second, so a reset pulse of one tick period lasts 500 ms. A two-bit state output shows whether the block is idle, armed, armed at the fallback frequency, or resetting.

Top module: `freq_watchdog`

## Requirements
- R1: After `rstN` is released, `wdState` is 0 (idle), `wdResetN` is 1 and `activeCode` equals `jumperCode`.
- R2: A write to the interval field takes effect only while the watchdog is idle (`wdState`=0). A write made while it is armed is ignored, and the armed count keeps using the old interval.
- R3: With interval code N≥1 written and the watchdog enabled, the watchdog expires on the N-th `halfTick` after the enable. At that clock edge `wdState` becomes 3 and `wdResetN` goes low (code 14 gives 7 s).
- R4: The reset pulse lasts exactly `PULSE_TICKS` tick periods (default 1, that is 500 ms). It ends at the edge where the last of those ticks is seen.
- R5: At the first expiry `activeCode` switches to the fallback field, which is bits 7:3 of `fallbackByte`. Once the pulse ends, the block re-arms at the same interval (`wdState`=2).
- R6: An expiry while in state 2 issues a second reset pulse and switches `activeCode` to `jumperCode`. When that pulse ends the block returns to idle.
- R7: Writing 0 to the enable field while armed (state 1 or 2) returns the block to idle with no pulse, and leaves `activeCode` unchanged.
- R8: An interval code of 0 expires on the first `halfTick` after the enable.
- R9: Writing 1 to the enable field while armed clears the tick count, so the full interval restarts.
- R10: An enable-field write during a reset pulse neither shortens the pulse nor changes the state that follows it.
- R11: A write on `swCodeIn` makes `activeCode` equal to the written code on the next cycle. A fallback or jumper switch made in the same cycle takes priority over it.
- R12: `wdState` encodes 0 = idle, 1 = armed, 2 = armed at the fallback frequency, 3 = resetting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfTick | input | 1 | Single-cycle strobe, one per half second |
| intervalWe | input | 1 | Write strobe for the interval field |
| intervalIn | input | 6 | Timeout interval in half-second steps |
| enableWe | input | 1 | Write strobe for the enable field |
| enableIn | input | 1 | Enable value: 1 arms or restarts, 0 disarms |
| fallbackWe | input | 1 | Write strobe for the fallback byte |
| fallbackByte | input | 8 | Byte whose bits 7:3 hold the fallback code |
| swCodeWe | input | 1 | Write strobe for the software frequency code |
| swCodeIn | input | 5 | Frequency code requested by software |
| jumperCode | input | 5 | Frequency code from the external jumpers |
| activeCode | output | 5 | Frequency code presented to the synthesizer |
| wdResetN | output | 1 | Active-low watchdog reset pulse |
| wdState | output | 2 | Watchdog state, encoded as in R12 |

## Verification
A table of interval codes is run, each paired with a tick count that stops either one tick before the expected expiry or exactly at it. This tells an off-by-one in the comparison apart from correct timing, and it covers the zero and single-step intervals. Directed sequences then cover the following cases:
- Both escalation levels run back to back, to separate the fallback source from the jumper source.
- A fallback byte with nonzero low bits, to show that only bits 7:3 are taken.
- A disarm before expiry.
- An interval write while armed.
- A restart write while armed.
- A disarm during the pulse.

Each of these changes the timing of the pulse only if the design gets that case wrong.

// File: rtl/freq_wdt_pkg.sv
package freq_wdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_ARMED     = 2'd1,
    ST_FB_ARMED  = 2'd2,
    ST_RESETTING = 2'd3
  } wdState_e;

  typedef enum logic [1:0] {
    SRC_JUMPER   = 2'd0,
    SRC_SOFT     = 2'd1,
    SRC_FALLBACK = 2'd2
  } codeSrc_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
    logic clrPulse;
    logic pulseEn;
    logic intervalOpen;
    logic loadFallback;
    logic loadJumper;
  } wdStrobe_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import freq_wdt_pkg::*;
#(
  parameter int IW          = 6,
  parameter int CW          = 5,
  parameter int BYTE_W      = 8,
  parameter int PULSE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              intervalWe,
  input  logic [IW-1:0]     intervalIn,
  input  logic              fallbackWe,
  input  logic [BYTE_W-1:0] fallbackByte,
  input  logic              swCodeWe,
  input  logic [CW-1:0]     swCodeIn,
  input  logic [CW-1:0]     jumperCode,
  input  wdStrobe_t         strb,
  output logic              expire,
  output logic              pulseDone,
  output logic [CW-1:0]     activeCode
);

  localparam int PCW    = $clog2(PULSE_TICKS + 1);
  localparam int FB_MSB = BYTE_W - 1;

  logic [IW-1:0]  intervalReg;
  logic [IW-1:0]  tickCnt;
  logic [IW:0]    tickNext;
  logic [PCW-1:0] pulseCnt;
  logic [PCW:0]   pulseNext;
  logic [CW-1:0]  fallbackReg;
  logic [CW-1:0]  softCode;
  codeSrc_e       codeSrc;

  // interval register: only writable while idle
  always_ff @(posedge clk) begin
    if (!rstN)                                intervalReg <= '0;
    else if (intervalWe && strb.intervalOpen) intervalReg <= intervalIn;
  end

  // fallback code is the top CW bits of its byte
  always_ff @(posedge clk) begin
    if (!rstN)           fallbackReg <= '0;
    else if (fallbackWe) fallbackReg <= fallbackByte[FB_MSB -: CW];
  end

  always_ff @(posedge clk) begin
    if (!rstN)         softCode <= '0;
    else if (swCodeWe) softCode <= swCodeIn;
  end

  // timeout counter
  assign tickNext = {1'b0, tickCnt} + 1'b1;
  assign expire   = halfTick && (tickNext >= {1'b0, intervalReg});

  always_ff @(posedge clk) begin
    if (!rstN)                       tickCnt <= '0;
    else if (strb.clrCnt)            tickCnt <= '0;
    else if (strb.cntEn && halfTick) tickCnt <= tickNext[IW-1:0];
  end

  // reset pulse width counter
  assign pulseNext = {1'b0, pulseCnt} + 1'b1;
  assign pulseDone = halfTick && (pulseNext >= (PCW+1)'(PULSE_TICKS));

  always_ff @(posedge clk) begin
    if (!rstN)                         pulseCnt <= '0;
    else if (strb.clrPulse)            pulseCnt <= '0;
    else if (strb.pulseEn && halfTick) pulseCnt <= pulseNext[PCW-1:0];
  end

  // frequency code source selection; recovery loads win over software writes
  always_ff @(posedge clk) begin
    if (!rstN)                  codeSrc <= SRC_JUMPER;
    else if (strb.loadJumper)   codeSrc <= SRC_JUMPER;
    else if (strb.loadFallback) codeSrc <= SRC_FALLBACK;
    else if (swCodeWe)          codeSrc <= SRC_SOFT;
  end

  always_comb begin
    unique case (codeSrc)
      SRC_SOFT:     activeCode = softCode;
      SRC_FALLBACK: activeCode = fallbackReg;
      default:      activeCode = jumperCode;
    endcase
  end

  p_interval_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.intervalOpen |=> $stable(intervalReg));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntEn && !strb.clrCnt) |-> (tickCnt <= intervalReg));

  p_fallback_applied_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadFallback && !fallbackWe) |=> (activeCode == $past(fallbackReg)));

  p_jumper_applied_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadJumper |=> (activeCode == jumperCode));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import freq_wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enableWe,
  input  logic      enableIn,
  input  logic      expire,
  input  logic      pulseDone,
  output wdState_e  state,
  output wdStrobe_t strb
);

  wdState_e nextState;
  logic     secondLevel;
  logic     nextSecond;

  always_comb begin
    nextState  = state;
    nextSecond = secondLevel;
    strb       = '0;
    unique case (state)
      ST_IDLE: begin
        strb.intervalOpen = 1'b1;
        if (enableWe && enableIn) begin
          nextState   = ST_ARMED;
          strb.clrCnt = 1'b1;
        end
      end
      ST_ARMED, ST_FB_ARMED: begin
        strb.cntEn = 1'b1;
        if (enableWe) begin
          strb.clrCnt = 1'b1;
          if (!enableIn) nextState = ST_IDLE;
        end else if (expire) begin
          nextState     = ST_RESETTING;
          strb.clrPulse = 1'b1;
          if (state == ST_ARMED) begin
            strb.loadFallback = 1'b1;
            nextSecond        = 1'b0;
          end else begin
            strb.loadJumper = 1'b1;
            nextSecond      = 1'b1;
          end
        end
      end
      default: begin
        strb.pulseEn = 1'b1;
        if (pulseDone) begin
          strb.clrCnt = 1'b1;
          nextState   = secondLevel ? ST_IDLE : ST_FB_ARMED;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      secondLevel <= 1'b0;
    end else begin
      state       <= nextState;
      secondLevel <= nextSecond;
    end
  end

  p_expire_enters_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ARMED || state == ST_FB_ARMED) && expire && !enableWe)
      |=> (state == ST_RESETTING));

  p_pulse_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESETTING && !pulseDone) |=> (state == ST_RESETTING));

  p_second_reset_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESETTING && pulseDone && secondLevel) |=> (state == ST_IDLE));

  p_first_reset_rearm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESETTING && pulseDone && !secondLevel) |=> (state == ST_FB_ARMED));

  p_disarm_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ARMED || state == ST_FB_ARMED) && enableWe && !enableIn)
      |=> (state == ST_IDLE));

endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
  import freq_wdt_pkg::*;
#(
  parameter int IW          = 6,
  parameter int CW          = 5,
  parameter int BYTE_W      = 8,
  parameter int PULSE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              intervalWe,
  input  logic [IW-1:0]     intervalIn,
  input  logic              enableWe,
  input  logic              enableIn,
  input  logic              fallbackWe,
  input  logic [BYTE_W-1:0] fallbackByte,
  input  logic              swCodeWe,
  input  logic [CW-1:0]     swCodeIn,
  input  logic [CW-1:0]     jumperCode,
  output logic [CW-1:0]     activeCode,
  output logic              wdResetN,
  output logic [1:0]        wdState
);

  wdState_e  state;
  wdStrobe_t strb;
  logic      expire;
  logic      pulseDone;

  wdt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enableWe  (enableWe),
    .enableIn  (enableIn),
    .expire    (expire),
    .pulseDone (pulseDone),
    .state     (state),
    .strb      (strb)
  );

  wdt_datapath #(
    .IW          (IW),
    .CW          (CW),
    .BYTE_W      (BYTE_W),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .halfTick     (halfTick),
    .intervalWe   (intervalWe),
    .intervalIn   (intervalIn),
    .fallbackWe   (fallbackWe),
    .fallbackByte (fallbackByte),
    .swCodeWe     (swCodeWe),
    .swCodeIn     (swCodeIn),
    .jumperCode   (jumperCode),
    .strb         (strb),
    .expire       (expire),
    .pulseDone    (pulseDone),
    .activeCode   (activeCode)
  );

  assign wdResetN = (state != ST_RESETTING);
  assign wdState  = state;

endmodule

// File: tb/freq_watchdog_test.sv
module freq_watchdog_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfTick = 1'b0;
  logic       intervalWe = 1'b0;
  logic [5:0] intervalIn = '0;
  logic       enableWe = 1'b0;
  logic       enableIn = 1'b0;
  logic       fallbackWe = 1'b0;
  logic [7:0] fallbackByte = '0;
  logic       swCodeWe = 1'b0;
  logic [4:0] swCodeIn = '0;
  logic [4:0] jumperCode = 5'd7;
  logic [4:0] activeCode;
  logic       wdResetN;
  logic [1:0] wdState;

  int checks = 0;
  int failures = 0;

  localparam int NVEC = 8;
  localparam int V_INTERVAL [NVEC] = '{3, 3, 0, 1, 5, 5, 14, 2};
  localparam int V_TICKS    [NVEC] = '{2, 3, 1, 1, 4, 5, 14, 1};

  freq_watchdog uut (
    .clk(clk), .rstN(rstN), .halfTick(halfTick),
    .intervalWe(intervalWe), .intervalIn(intervalIn),
    .enableWe(enableWe), .enableIn(enableIn),
    .fallbackWe(fallbackWe), .fallbackByte(fallbackByte),
    .swCodeWe(swCodeWe), .swCodeIn(swCodeIn), .jumperCode(jumperCode),
    .activeCode(activeCode), .wdResetN(wdResetN), .wdState(wdState)
  );

  always #5 clk = ~clk;

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hardReset();
    @(negedge clk);
    rstN = 1'b0;
    halfTick = 0; intervalWe = 0; enableWe = 0; fallbackWe = 0; swCodeWe = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // one tick period = 4 clock cycles
  task automatic doTick();
    halfTick = 1'b1;
    @(negedge clk);
    halfTick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) doTick();
  endtask

  task automatic wrInterval(input int v);
    intervalWe = 1'b1; intervalIn = 6'(v);
    @(negedge clk);
    intervalWe = 1'b0;
  endtask

  task automatic wrEnable(input bit v);
    enableWe = 1'b1; enableIn = v;
    @(negedge clk);
    enableWe = 1'b0;
  endtask

  task automatic wrFallback(input logic [7:0] b);
    fallbackWe = 1'b1; fallbackByte = b;
    @(negedge clk);
    fallbackWe = 1'b0;
  endtask

  task automatic wrSoft(input int c);
    swCodeWe = 1'b1; swCodeIn = 5'(c);
    @(negedge clk);
    swCodeWe = 1'b0;
  endtask

  function automatic int expState(input int n, input int k);
    int lim;
    lim = (n == 0) ? 1 : n;
    return (k >= lim) ? 3 : 1;
  endfunction

  initial begin
    int es;

    // R1 / R12: reset state
    hardReset();
    check("R1 state", wdState, 0);
    check("R1 resetN", wdResetN, 1);
    check("R1 code", activeCode, 7);

    // table: interval vs ticks applied (R3, R8, R5)
    for (int v = 0; v < NVEC; v++) begin
      hardReset();
      wrFallback(8'b1001_1011);   // field bits 7:3 = 19
      wrSoft(12);
      wrInterval(V_INTERVAL[v]);
      wrEnable(1'b1);
      ticks(V_TICKS[v]);
      es = expState(V_INTERVAL[v], V_TICKS[v]);
      check("R3 R8 state", wdState, es);
      check("R3 resetN", wdResetN, (es == 3) ? 0 : 1);
      check("R5 R11 code", activeCode, (es == 3) ? 19 : 12);
    end

    // full escalation: R5, R4, R6, R13-style field check in R5
    hardReset();
    jumperCode = 5'd9;
    wrFallback(8'b1010_0101);     // bits 7:3 = 20, low bits ignored
    wrSoft(3);
    check("R11 soft code", activeCode, 3);
    wrInterval(2);
    wrEnable(1'b1);
    ticks(2);
    check("R5 first reset state", wdState, 3);
    check("R5 fallback code", activeCode, 20);
    repeat (2) @(negedge clk);
    check("R4 pulse still low", wdResetN, 0);
    doTick();
    check("R4 pulse ended", wdResetN, 1);
    check("R5 rearmed at fallback", wdState, 2);
    doTick();
    check("R5 same interval not yet", wdState, 2);
    doTick();
    check("R6 second reset", wdState, 3);
    check("R6 jumper code", activeCode, 9);
    doTick();
    check("R6 back to idle", wdState, 0);
    check("R6 resetN high", wdResetN, 1);

    // R7: disarm before expiry
    hardReset();
    wrSoft(4);
    wrInterval(3);
    wrEnable(1'b1);
    ticks(2);
    wrEnable(1'b0);
    check("R7 idle after disarm", wdState, 0);
    ticks(5);
    check("R7 no pulse", wdResetN, 1);
    check("R7 code kept", activeCode, 4);

    // R2: interval write while armed ignored
    hardReset();
    wrInterval(4);
    wrEnable(1'b1);
    wrInterval(1);
    ticks(1);
    check("R2 armed write ignored", wdState, 1);
    ticks(3);
    check("R2 old interval expires", wdState, 3);

    // R9: restart write clears count
    hardReset();
    wrInterval(3);
    wrEnable(1'b1);
    ticks(2);
    wrEnable(1'b1);
    ticks(2);
    check("R9 count restarted", wdState, 1);
    doTick();
    check("R9 expires after full interval", wdState, 3);

    // R10: disarm during pulse
    hardReset();
    wrFallback(8'b0011_1000);     // bits 7:3 = 7
    wrInterval(1);
    wrEnable(1'b1);
    doTick();
    wrEnable(1'b0);
    check("R10 pulse continues", wdResetN, 0);
    check("R10 state held", wdState, 3);
    doTick();
    check("R10 next state fallback armed", wdState, 2);
    wrEnable(1'b0);
    check("R7 disarm at fallback idle", wdState, 0);
    check("R7 fallback code kept", activeCode, 7);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule